// File: doc/BRIEF.md
# Two-Key Register Write Gate

This block stands between a register bus and a bank of six control registers (time, date, control, status/init, prescaler and alarm). It passes a write strobe to one of those registers only when two conditions hold. First, the bank has been unlocked by writing two key bytes, one after the other, to a dedicated key address. Second, an external domain-enable input is high. Register storage is outside this block. The block only decides whether each write strobe reaches its target.

A key write with any value other than the one the sequence expects puts the bank back into the locked state. If that value is the first key byte, it starts the sequence again. Software therefore unlocks the bank with the two key bytes, performs its register updates, and then relocks it with a write of any non-key value such as 0xFF. Bus writes to addresses that are neither protected nor the key address have no effect on the key sequence. A status output shows whether the bank is currently open.

Top module: `wprot_gate`

## Requirements
- R1: While reset is asserted, and after it is released, the gate is locked: `unlocked_o` is 0 and no strobe is asserted. Reset is asserted asynchronously and its release is synchronised to the clock.
- R2: A key write (address 7, with `bus_we_i` and `domain_en_i` high) carrying 0xCA, followed by a key write carrying 0x53, sets `unlocked_o` on the clock edge that takes the second write.
- R3: While locked, including the state after only the first key byte, writes to protected addresses assert no strobe.
- R4: While unlocked and with `domain_en_i` high, a write to protected address k (0 time, 1 date, 2 control, 3 status/init, 4 prescaler, 5 alarm) asserts `wr_strobe_o[k]` in the same cycle and no other strobe bit.
- R5: While `domain_en_i` is low, no strobe is asserted and key writes leave the lock state unchanged.
- R6: In the first-key stage, a key write other than 0x53 relocks the gate. If that value is 0xCA, the sequence restarts, so a following 0x53 unlocks the gate.
- R7: While unlocked, any key write relocks the gate. A value of 0xCA also enters the first-key stage.
- R8: Writes to addresses 8 to 15 never assert a strobe and neither advance nor break the key sequence.
- R9: Only bits 7:0 of the write data take part in the key comparison. Bits 31:8 are ignored.
- R10: At most one strobe bit is high at any time, and no strobe is asserted while `bus_we_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe from the bus |
| domain_en_i | input | 1 | External domain write enable |
| wr_strobe_o | output | 6 | Gated write strobes, one per protected register |
| unlocked_o | output | 1 | High while the bank is open for writes |

## Verification
The first-key stage has no output of its own, which makes it the hardest state to observe. It looks exactly like the locked state at the ports, so the stimulus can only reveal it through what happens next. The vector table therefore places several different writes after a lone 0xCA and checks whether a 0x53 that follows still opens the gate. Those intervening writes are a repeated 0xCA, a write to an unprotected address, a wrong byte, and a 0xCA carrying non-zero upper bits. The table also probes key writes made while the domain enable is low, and a reset asserted while the gate is open.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_ARMED  = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_state_e;

  localparam int unsigned SEL_TIME  = 0;
  localparam int unsigned SEL_DATE  = 1;
  localparam int unsigned SEL_CTRL  = 2;
  localparam int unsigned SEL_STAT  = 3;
  localparam int unsigned SEL_PRESC = 4;
  localparam int unsigned SEL_ALARM = 5;
  localparam int unsigned SEL_COUNT = 6;

endpackage

// File: rtl/wprot_rst_sync.sv
module wprot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/wprot_addr_decode.sv
module wprot_addr_decode #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned N_PROT    = 6,
  parameter int unsigned PROT_BASE = 0,
  parameter int unsigned KEY_ADDR  = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_PROT-1:0] prot_hit_o,
  output logic              key_hit_o
);

  for (genvar g = 0; g < N_PROT; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(PROT_BASE + g);
    assign prot_hit_o[g] = (addr_i == SLOT_ADDR);
  end

  assign key_hit_o = (addr_i == ADDR_W'(KEY_ADDR));

endmodule

// File: rtl/wprot_key_fsm.sv
module wprot_key_fsm
  import wprot_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned KEY_W      = 8,
  parameter logic [7:0]  KEY_FIRST  = 8'hCA,
  parameter logic [7:0]  KEY_SECOND = 8'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] key_data_i,
  output logic              unlocked_o
);

  localparam logic [DATA_W-1:0] KEY_MASK = DATA_W'((64'd1 << KEY_W) - 64'd1);
  localparam logic [DATA_W-1:0] FIRST_W  = DATA_W'(KEY_FIRST);
  localparam logic [DATA_W-1:0] SECOND_W = DATA_W'(KEY_SECOND);

  gate_state_e state_q, state_d;
  logic        is_first, is_second;

  assign is_first  = ((key_data_i & KEY_MASK) == FIRST_W);
  assign is_second = ((key_data_i & KEY_MASK) == SECOND_W);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_LOCKED: state_d = is_first ? GATE_ARMED : GATE_LOCKED;
      GATE_ARMED: begin
        if (is_second)     state_d = GATE_OPEN;
        else if (is_first) state_d = GATE_ARMED;
        else               state_d = GATE_LOCKED;
      end
      GATE_OPEN:   state_d = is_first ? GATE_ARMED : GATE_LOCKED;
      default:     state_d = GATE_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_LOCKED;
    end else if (key_wr_i) begin
      state_q <= state_d;
    end
  end

  assign unlocked_o = (state_q == GATE_OPEN);

  // R2
  open_needs_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> $past(key_wr_i && is_second));

  // R7
  open_key_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked_o && key_wr_i) |=> !unlocked_o);

endmodule

// File: rtl/wprot_strobe_gate.sv
module wprot_strobe_gate #(
  parameter int unsigned N_PROT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              domain_en_i,
  input  logic              unlocked_i,
  input  logic [N_PROT-1:0] prot_hit_i,
  output logic [N_PROT-1:0] strobe_o
);

  logic pass_en;

  assign pass_en  = we_i & domain_en_i & unlocked_i;
  assign strobe_o = prot_hit_i & {N_PROT{pass_en}};

  // R3
  locked_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_i |-> (strobe_o == '0));

  // R5
  domain_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !domain_en_i |-> (strobe_o == '0));

  // R10
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_o));

  // R10
  no_we_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |-> (strobe_o == '0));

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned KEY_W      = 8,
  parameter int unsigned N_PROT     = wprot_pkg::SEL_COUNT,
  parameter int unsigned PROT_BASE  = 0,
  parameter int unsigned KEY_ADDR   = 7,
  parameter logic [7:0]  KEY_FIRST  = 8'hCA,
  parameter logic [7:0]  KEY_SECOND = 8'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  input  logic              domain_en_i,
  output logic [N_PROT-1:0] wr_strobe_o,
  output logic              unlocked_o
);

  logic              rst_q_n;
  logic [N_PROT-1:0] prot_hit;
  logic              key_hit;
  logic              key_wr;

  wprot_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_sync_n_o (rst_q_n)
  );

  wprot_addr_decode #(
    .ADDR_W    (ADDR_W),
    .N_PROT    (N_PROT),
    .PROT_BASE (PROT_BASE),
    .KEY_ADDR  (KEY_ADDR)
  ) i_decode (
    .addr_i     (bus_addr_i),
    .prot_hit_o (prot_hit),
    .key_hit_o  (key_hit)
  );

  assign key_wr = bus_we_i & domain_en_i & key_hit;

  wprot_key_fsm #(
    .DATA_W     (DATA_W),
    .KEY_W      (KEY_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) i_key_fsm (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .key_wr_i   (key_wr),
    .key_data_i (bus_wdata_i),
    .unlocked_o (unlocked_o)
  );

  wprot_strobe_gate #(.N_PROT(N_PROT)) i_gate (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .we_i        (bus_we_i),
    .domain_en_i (domain_en_i),
    .unlocked_i  (unlocked_o),
    .prot_hit_i  (prot_hit),
    .strobe_o    (wr_strobe_o)
  );

  // R5
  domain_low_holds_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !domain_en_i |=> $stable(unlocked_o));

  // R8
  other_addr_holds_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_we_i && (bus_addr_i != ADDR_W'(KEY_ADDR))) |=> $stable(unlocked_o));

endmodule

// File: tb/test_wprot_gate.sv
module test_wprot_gate;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;

  logic        clk;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic        domain_en;
  logic [5:0]  wr_strobe;
  logic        unlocked;

  int total = 0;
  int bad = 0;
  bit done = 0;

  wprot_gate i_wprot_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_we_i    (bus_we),
    .domain_en_i (domain_en),
    .wr_strobe_o (wr_strobe),
    .unlocked_o  (unlocked)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // entry: {req[48:45], we[44], dom[43], addr[42:39], data[38:7], strobe[6:1], open[0]}
  localparam logic [48:0] VECS [NV] = '{
    {4'd3,  1'b1, 1'b1, 4'h2, 32'h0000_0011, 6'h00, 1'b0}, // R3 locked
    {4'd2,  1'b1, 1'b1, 4'h7, 32'h0000_00CA, 6'h00, 1'b0}, // R2 first key
    {4'd3,  1'b1, 1'b1, 4'h2, 32'h0000_0022, 6'h00, 1'b0}, // R3 armed only
    {4'd2,  1'b1, 1'b1, 4'h7, 32'h0000_0053, 6'h00, 1'b1}, // R2 second key
    {4'd4,  1'b1, 1'b1, 4'h0, 32'h0000_0001, 6'h01, 1'b1}, // R4 time
    {4'd4,  1'b1, 1'b1, 4'h1, 32'h0000_0002, 6'h02, 1'b1}, // R4 date
    {4'd4,  1'b1, 1'b1, 4'h2, 32'h0000_0003, 6'h04, 1'b1}, // R4 control
    {4'd4,  1'b1, 1'b1, 4'h3, 32'h0000_0004, 6'h08, 1'b1}, // R4 status
    {4'd4,  1'b1, 1'b1, 4'h4, 32'h0000_0005, 6'h10, 1'b1}, // R4 prescaler
    {4'd4,  1'b1, 1'b1, 4'h5, 32'h0000_0006, 6'h20, 1'b1}, // R4 alarm
    {4'd8,  1'b1, 1'b1, 4'h9, 32'h0000_00FF, 6'h00, 1'b1}, // R8 other address
    {4'd10, 1'b0, 1'b1, 4'h2, 32'h0000_0007, 6'h00, 1'b1}, // R10 no we
    {4'd5,  1'b1, 1'b0, 4'h3, 32'h0000_0008, 6'h00, 1'b1}, // R5 domain low
    {4'd5,  1'b1, 1'b0, 4'h7, 32'h0000_00FF, 6'h00, 1'b1}, // R5 key ignored
    {4'd7,  1'b1, 1'b1, 4'h7, 32'h0000_00FF, 6'h00, 1'b0}, // R7 relock
    {4'd6,  1'b1, 1'b1, 4'h7, 32'h0000_00CA, 6'h00, 1'b0}, // R6 first key
    {4'd6,  1'b1, 1'b1, 4'h7, 32'h0000_00CA, 6'h00, 1'b0}, // R6 restart
    {4'd8,  1'b1, 1'b1, 4'hC, 32'h0000_0000, 6'h00, 1'b0}, // R8 between keys
    {4'd6,  1'b1, 1'b1, 4'h7, 32'h0000_0053, 6'h00, 1'b1}, // R6 then R8 unlock
    {4'd7,  1'b1, 1'b1, 4'h7, 32'h0000_00CA, 6'h00, 1'b0}, // R7 first key while open
    {4'd7,  1'b1, 1'b1, 4'h7, 32'h0000_0053, 6'h00, 1'b1}, // R7 reopen
    {4'd7,  1'b1, 1'b1, 4'h7, 32'h0000_0053, 6'h00, 1'b0}, // R7 second key relocks
    {4'd6,  1'b1, 1'b1, 4'h7, 32'h0000_00CA, 6'h00, 1'b0}, // R6 arm
    {4'd6,  1'b1, 1'b1, 4'h7, 32'h0000_0077, 6'h00, 1'b0}, // R6 wrong byte
    {4'd6,  1'b1, 1'b1, 4'h7, 32'h0000_0053, 6'h00, 1'b0}, // R6 stays locked
    {4'd9,  1'b1, 1'b1, 4'h7, 32'hABCD_12CA, 6'h00, 1'b0}, // R9 upper bits
    {4'd9,  1'b1, 1'b1, 4'h7, 32'hFFFF_FF53, 6'h00, 1'b1}, // R9 upper bits
    {4'd4,  1'b1, 1'b1, 4'h5, 32'h0000_0009, 6'h20, 1'b1}  // R4 alarm again
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic we, input logic dom, input logic [3:0] a, input logic [31:0] d);
    bus_we    = we;
    domain_en = dom;
    bus_addr  = a;
    bus_wdata = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 4'h0, 32'h0);
    #1;
    // R1: reset state
    check("R1 strobe in reset", 32'(wr_strobe), 32'h0);
    check("R1 unlocked in reset", 32'(unlocked), 32'h0);
    drive(1'b0, 1'b1, 4'h0, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 unlocked after release", 32'(unlocked), 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [48:0] e;
      string tag;
      e = VECS[v];
      tag = $sformatf("R%0d vec%0d", e[48:45], v);
      @(negedge clk);
      drive(e[44], e[43], e[42:39], e[38:7]);
      #1;
      check({tag, " strobe"}, 32'(wr_strobe), 32'(e[6:1]));
      // R10: at most one strobe
      check({tag, " R10 onehot"}, 32'($countones(wr_strobe) <= 1), 32'h1);
      @(posedge clk);
      #1;
      check({tag, " unlocked"}, 32'(unlocked), 32'(e[0]));
    end

    // R1: asynchronous reset while open
    @(negedge clk);
    drive(1'b1, 1'b1, 4'h0, 32'h0);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run unlocked", 32'(unlocked), 32'h0);
    check("R1 mid-run strobe", 32'(wr_strobe), 32'h0);
    drive(1'b0, 1'b1, 4'h0, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3: after reset a protected write is blocked
    drive(1'b1, 1'b1, 4'h1, 32'h5);
    #1;
    check("R3 after reset strobe", 32'(wr_strobe), 32'h0);
    @(negedge clk);
    drive(1'b0, 1'b1, 4'h0, 32'h0);
    @(posedge clk);
    #1;
    check("R1 still locked", 32'(unlocked), 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule